// File: doc/BRIEF.md
# Write-Protect Command Sequence Detector

This block sits beside a paged non-volatile memory controller and watches every host write strobe. Fixed address/data unlock sequences switch a persistent write-protect state on and off. A three-write sequence turns protection on and also authorises the page load that follows it. A six-write sequence turns protection off and likewise opens a load window. The bytes that form a sequence are marked so that the page controller does not store them. The protect state itself changes only when the page controller reports the end of its programming period.

For each strobe the block tells the page controller three things. The first is whether the write is a command byte. The second is whether the write counts as a page-load event that starts or extends the write period. The third is whether its data may really be stored. While protection is on, a write outside an authorised window still counts as a load event, so the device reads as busy, but nothing is stored. A sequence is abandoned when the gap between consecutive writes exceeds the page-load timeout. It is also abandoned by a write that is not the expected next step.

Two resets are provided. The hard reset stands for a power cycle onto the default unprotected state. The soft reset clears only the matcher, so protection survives it.

Top module: `wp_seq_detect`

## Requirements
- R1: A hard reset (`rst_hard_n` low) clears `protect_o` to 0 and returns the matcher to idle, so that the next write is an ordinary write.
- R2: The enable sequence is three writes: data 0xAA to address 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555. Each of these writes raises `seq_byte_o` and never raises `store_o`.
- R3: The disable sequence is six writes: 0xAA to 0x5555, 0x55 to 0x2AAA, 0x80 to 0x5555, 0xAA to 0x5555, 0x55 to 0x2AAA, 0x20 to 0x5555. Each of these writes raises `seq_byte_o` and never raises `store_o`.
- R4: Address matching uses only `wr_addr[14:0]`. Bits above 14 have no effect on whether a write matches a step.
- R5: `protect_o` changes only in the cycle after a `prog_done` pulse. It becomes 1 if an enable sequence completed since the last pulse, and 0 if a disable sequence completed, even when no data byte followed. Otherwise it keeps its value.
- R6: While `protect_o` is 1, a non-command write stores (`store_o`=1) only inside the load window opened by a completed sequence.
- R7: While `protect_o` is 1, a non-command write outside such a window gives `load_o`=1 and `store_o`=0.
- R8: While `protect_o` is 0, every non-command write gives `store_o`=1 and `load_o`=1.
- R9: The last write of a sequence raises `load_o` so that the write period starts. Earlier sequence writes leave `load_o` at 0.
- R10: A write that does not match the expected next step returns the matcher to idle. That write is handled as an ordinary write, even if it equals the first step.
- R11: A sequence or load window continues when consecutive writes are at most `TIMEOUT_CYC` cycles apart, strobe to strobe. A larger gap abandons it.
- R12: A soft reset (`rst_soft_n` low) returns the matcher to idle and drops a pending protect change, but leaves `protect_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_hard_n | input | 1 | Synchronous active-low power-on reset; clears all state including protection |
| rst_soft_n | input | 1 | Synchronous active-low reset of the matcher and pending change only |
| wr_stb | input | 1 | One-cycle host write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| prog_done | input | 1 | One-cycle pulse at the end of the programming period |
| protect_o | output | 1 | Current write-protect state |
| seq_byte_o | output | 1 | This write is a command-sequence byte and must not be stored |
| load_o | output | 1 | This write counts as a page-load event (starts the write period) |
| store_o | output | 1 | This write's data may be stored in the array |

## Verification
A matcher stuck in the wrong step shows on the very next strobe. In that cycle `seq_byte_o` and `load_o` take the wrong values for the written address and data. A lost or wrong pending change shows only at the next `prog_done`, one cycle later on `protect_o`. For that reason the stimulus always follows a sequence with a programming-end pulse and then a probe write. A window that closes too early or too late shows as a wrong `store_o` on a protected write placed exactly at, and one cycle past, the timeout distance.

// File: rtl/wpd_pkg.sv
package wpd_pkg;

    // Width of the address field that takes part in sequence matching.
    localparam int CMP_W = 15;

    localparam logic [CMP_W-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [CMP_W-1:0] KEY_ADDR_B = 15'h2AAA;

    localparam logic [7:0] KEY_AA = 8'hAA;
    localparam logic [7:0] KEY_55 = 8'h55;
    localparam logic [7:0] KEY_A0 = 8'hA0;
    localparam logic [7:0] KEY_80 = 8'h80;
    localparam logic [7:0] KEY_20 = 8'h20;

    // Matcher progress. ST_OPEN is the authorised load window.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_K1,
        ST_K2,
        ST_X1,
        ST_X2,
        ST_X3,
        ST_OPEN
    } step_e;

    typedef enum logic [1:0] {
        PD_NONE,
        PD_SET,
        PD_CLR
    } pend_e;

    typedef struct packed {
        step_e step;
        pend_e pend;
    } seq_s;

    // One flag per distinct address/data pair used by the sequences.
    typedef struct packed {
        logic k_aa;
        logic k_55;
        logic k_a0;
        logic k_80;
        logic k_20;
    } key_s;

endpackage

// File: rtl/wpd_cmd_decode.sv
module wpd_cmd_decode
    import wpd_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output key_s              keys
);

    logic at_a;
    logic at_b;

    assign at_a = (addr[CMP_W-1:0] == KEY_ADDR_A);
    assign at_b = (addr[CMP_W-1:0] == KEY_ADDR_B);

    assign keys.k_aa = at_a && (data == KEY_AA);
    assign keys.k_55 = at_b && (data == KEY_55);
    assign keys.k_a0 = at_a && (data == KEY_A0);
    assign keys.k_80 = at_a && (data == KEY_80);
    assign keys.k_20 = at_a && (data == KEY_20);

    // Upper address bits take no part in matching.
    generate
        if (ADDR_W > CMP_W) begin : g_upper
            logic unused_upper;
            assign unused_upper = ^addr[ADDR_W-1:CMP_W];
        end
    endgenerate

endmodule

// File: rtl/wpd_gap_timer.sv
module wpd_gap_timer #(
    parameter int TIMEOUT_CYC = 18750
) (
    input  logic clk,
    input  logic clr_n,
    input  logic stb,
    input  logic run,
    output logic expire
);

    localparam int CW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;

    // Expires after TIMEOUT_CYC strobe-free edges while a sequence is live.
    assign expire = run && !stb && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (stb || !run || expire) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!clr_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/wp_seq_detect.sv
module wp_seq_detect
    import wpd_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int TIMEOUT_CYC = 18750
) (
    input  logic              clk,
    input  logic              rst_hard_n,
    input  logic              rst_soft_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              prog_done,
    output logic              protect_o,
    output logic              seq_byte_o,
    output logic              load_o,
    output logic              store_o
);

    key_s  keys;
    seq_s  seq_d, seq_q;
    logic  prot_d, prot_q;
    logic  gap_expire;
    logic  hit;
    logic  fin;
    pend_e fin_pend;
    step_e nxt;
    logic  matcher_idle;
    logic  in_open;
    logic  clr_n;

    assign clr_n        = rst_hard_n && rst_soft_n;
    assign matcher_idle = (seq_q.step == ST_IDLE);
    assign in_open      = (seq_q.step == ST_OPEN);

    wpd_cmd_decode #(
        .ADDR_W (ADDR_W)
    ) dec_i (
        .addr (wr_addr),
        .data (wr_data),
        .keys (keys)
    );

    wpd_gap_timer #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) gap_i (
        .clk    (clk),
        .clr_n  (clr_n),
        .stb    (wr_stb),
        .run    (!matcher_idle),
        .expire (gap_expire)
    );

    // Step matching: which key the current step expects.
    always_comb begin
        hit      = 1'b0;
        fin      = 1'b0;
        fin_pend = PD_NONE;
        nxt      = ST_IDLE;
        unique case (seq_q.step)
            ST_IDLE: if (keys.k_aa) begin hit = 1'b1; nxt = ST_K1; end
            ST_K1:   if (keys.k_55) begin hit = 1'b1; nxt = ST_K2; end
            ST_K2: begin
                if (keys.k_a0) begin
                    hit      = 1'b1;
                    fin      = 1'b1;
                    fin_pend = PD_SET;
                    nxt      = ST_OPEN;
                end else if (keys.k_80) begin
                    hit = 1'b1;
                    nxt = ST_X1;
                end
            end
            ST_X1:   if (keys.k_aa) begin hit = 1'b1; nxt = ST_X2; end
            ST_X2:   if (keys.k_55) begin hit = 1'b1; nxt = ST_X3; end
            ST_X3: begin
                if (keys.k_20) begin
                    hit      = 1'b1;
                    fin      = 1'b1;
                    fin_pend = PD_CLR;
                    nxt      = ST_OPEN;
                end
            end
            default: nxt = ST_OPEN;
        endcase
    end

    // Next-state computation.
    always_comb begin
        seq_d  = seq_q;
        prot_d = prot_q;

        if (wr_stb) begin
            seq_d.step = nxt;
        end else if (gap_expire) begin
            seq_d.step = ST_IDLE;
        end

        if (prog_done) begin
            unique case (seq_q.pend)
                PD_SET:  prot_d = 1'b1;
                PD_CLR:  prot_d = 1'b0;
                default: prot_d = prot_q;
            endcase
        end

        if (wr_stb && fin) begin
            seq_d.pend = fin_pend;
        end else if (prog_done) begin
            seq_d.pend = PD_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!clr_n) begin
            seq_q <= '{step: ST_IDLE, pend: PD_NONE};
        end else begin
            seq_q <= seq_d;
        end
    end

    // Protect state survives the soft reset.
    always_ff @(posedge clk) begin
        if (!rst_hard_n) begin
            prot_q <= 1'b0;
        end else begin
            prot_q <= prot_d;
        end
    end

    assign protect_o  = prot_q;
    assign seq_byte_o = wr_stb && hit;
    assign load_o     = wr_stb && (!hit || fin);
    assign store_o    = wr_stb && !hit && (!prot_q || in_open);

endmodule

// File: rtl/wp_seq_detect_chk.sv
module wp_seq_detect_chk #(
    parameter int TIMEOUT_CYC = 18750
) (
    input logic clk,
    input logic rst_hard_n,
    input logic rst_soft_n,
    input logic wr_stb,
    input logic prog_done,
    input logic protect_o,
    input logic seq_byte_o,
    input logic load_o,
    input logic store_o,
    input logic matcher_idle,
    input logic in_open
);

    int gap_q;

    always_ff @(posedge clk) begin
        if (!rst_hard_n || !rst_soft_n) begin
            gap_q <= TIMEOUT_CYC;
        end else if (wr_stb) begin
            gap_q <= 0;
        end else if (gap_q < TIMEOUT_CYC) begin
            gap_q <= gap_q + 1;
        end
    end

    AST_PROT_RISE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_hard_n)
        $rose(protect_o) |-> $past(prog_done)); // R5

    AST_PROT_FALL_ON_DONE: assert property (@(posedge clk) disable iff (!rst_hard_n)
        $fell(protect_o) |-> $past(prog_done)); // R5

    AST_SOFT_RESET_KEEPS_PROT: assert property (@(posedge clk) disable iff (!rst_hard_n)
        (!rst_soft_n && !prog_done) |=> $stable(protect_o)); // R12

    AST_PROT_STORE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_hard_n || !rst_soft_n)
        (protect_o && store_o) |-> in_open); // R6

    AST_UNPROT_STORES: assert property (@(posedge clk) disable iff (!rst_hard_n || !rst_soft_n)
        (wr_stb && !protect_o && !seq_byte_o) |-> (store_o && load_o)); // R8

    AST_NO_OUTPUT_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_hard_n || !rst_soft_n)
        !wr_stb |-> (!store_o && !load_o && !seq_byte_o)); // R7

    AST_GAP_ABANDONS: assert property (@(posedge clk) disable iff (!rst_hard_n || !rst_soft_n)
        (gap_q >= TIMEOUT_CYC) |-> matcher_idle); // R11

endmodule

bind wp_seq_detect wp_seq_detect_chk #(
    .TIMEOUT_CYC (TIMEOUT_CYC)
) chk_i (
    .clk          (clk),
    .rst_hard_n   (rst_hard_n),
    .rst_soft_n   (rst_soft_n),
    .wr_stb       (wr_stb),
    .prog_done    (prog_done),
    .protect_o    (protect_o),
    .seq_byte_o   (seq_byte_o),
    .load_o       (load_o),
    .store_o      (store_o),
    .matcher_idle (matcher_idle),
    .in_open      (in_open)
);

// File: tb/wp_seq_detect_tb.sv
module wp_seq_detect_tb_top;

    localparam int T  = 8;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst_hard_n = 1'b0;
    logic          rst_soft_n = 1'b1;
    logic          wr_stb = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          prog_done = 1'b0;
    logic          protect_o, seq_byte_o, load_o, store_o;

    always #4 clk = ~clk;

    wp_seq_detect #(.ADDR_W(AW), .TIMEOUT_CYC(T)) dut_i (
        .clk        (clk),
        .rst_hard_n (rst_hard_n),
        .rst_soft_n (rst_soft_n),
        .wr_stb     (wr_stb),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .prog_done  (prog_done),
        .protect_o  (protect_o),
        .seq_byte_o (seq_byte_o),
        .load_o     (load_o),
        .store_o    (store_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    // Reference model: step 0 idle, 1..5 partial sequence, 6 open window.
    int m_step = 0;
    int m_pend = 0;   // 0 none, 1 set, 2 clear
    int m_last = 0;
    bit m_prot = 1'b0;
    bit obs_seq, obs_load, obs_store, obs_prot;

    localparam logic [AW-1:0] A5 = 17'h05555;
    localparam logic [AW-1:0] A2 = 17'h02AAA;

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic cyc1(input bit stb, input logic [AW-1:0] a, input logic [7:0] d, input bit done);
        bit hit, fin;
        int nstep, fpend;
        bit kaa, k55, ka0, k80, k20;
        bit e_seq, e_load, e_store;
        @(negedge clk);
        wr_stb = stb; wr_addr = a; wr_data = d; prog_done = done;
        #2;
        kaa = (a[14:0] == 15'h5555) && (d == 8'hAA);
        k55 = (a[14:0] == 15'h2AAA) && (d == 8'h55);
        ka0 = (a[14:0] == 15'h5555) && (d == 8'hA0);
        k80 = (a[14:0] == 15'h5555) && (d == 8'h80);
        k20 = (a[14:0] == 15'h5555) && (d == 8'h20);
        if (m_step != 0 && (cyc - m_last) > T) m_step = 0;
        hit = 0; fin = 0; nstep = 0; fpend = 0;
        case (m_step)
            0: if (kaa) begin hit = 1; nstep = 1; end
            1: if (k55) begin hit = 1; nstep = 2; end
            2: if (ka0) begin hit = 1; fin = 1; fpend = 1; nstep = 6; end
               else if (k80) begin hit = 1; nstep = 3; end
            3: if (kaa) begin hit = 1; nstep = 4; end
            4: if (k55) begin hit = 1; nstep = 5; end
            5: if (k20) begin hit = 1; fin = 1; fpend = 2; nstep = 6; end
            default: nstep = 6;
        endcase
        e_seq   = stb && hit;
        e_load  = stb && (!hit || fin);
        e_store = stb && !hit && (!m_prot || m_step == 6);
        obs_seq = seq_byte_o; obs_load = load_o; obs_store = store_o; obs_prot = protect_o;
        chk("R2 seq_byte_o", seq_byte_o, e_seq);
        chk("R9 load_o", load_o, e_load);
        chk("R7 store_o", store_o, e_store);
        chk("R5 protect_o", protect_o, m_prot);
        if (done) begin
            if (m_pend == 1) m_prot = 1;
            if (m_pend == 2) m_prot = 0;
            m_pend = 0;
        end
        if (stb && fin) m_pend = fpend;
        if (stb) begin
            m_step = nstep;
            m_last = cyc;
        end
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc1(0, '0, '0, 0);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        cyc1(1, a, d, 0);
    endtask

    task automatic finish_prog();
        idle(T + 2);
        cyc1(0, '0, '0, 1);
        idle(1);
    endtask

    task automatic hard_reset();
        @(negedge clk);
        rst_hard_n = 0; wr_stb = 0; prog_done = 0;
        repeat (2) @(negedge clk);
        rst_hard_n = 1;
        m_prot = 0; m_step = 0; m_pend = 0;
    endtask

    task automatic soft_reset();
        @(negedge clk);
        rst_soft_n = 0; wr_stb = 0; prog_done = 0;
        repeat (2) @(negedge clk);
        rst_soft_n = 1;
        m_step = 0; m_pend = 0;
    endtask

    task automatic enable_seq(input logic [1:0] hi);
        wr({hi, 15'h5555}, 8'hAA);
        wr({hi, 15'h2AAA}, 8'h55);
        wr({hi, 15'h5555}, 8'hA0);
    endtask

    initial begin : watchdog
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        hard_reset();
        idle(1);
        chk("R1 protect after hard reset", obs_prot, 1'b0);

        // Unprotected ordinary write.
        wr(17'h00123, 8'h3C);
        chk("R8 unprotected store", obs_store, 1'b1);
        chk("R8 unprotected load", obs_load, 1'b1);

        // Enable sequence followed by data.
        wr(A5, 8'hAA);
        chk("R2 first enable byte flagged", obs_seq, 1'b1);
        chk("R9 first byte no load", obs_load, 1'b0);
        wr(A2, 8'h55);
        wr(A5, 8'hA0);
        chk("R2 last enable byte not stored", obs_store, 1'b0);
        chk("R9 last byte starts load", obs_load, 1'b1);
        wr(17'h00200, 8'h11);
        wr(17'h00201, 8'h22);
        chk("R5 protect still 0 before done", obs_prot, 1'b0);
        finish_prog();
        chk("R5 protect set after done", obs_prot, 1'b1);

        // Unauthorised protected write.
        wr(17'h00300, 8'h99);
        chk("R7 protected unauthorised no store", obs_store, 1'b0);
        chk("R7 protected unauthorised load", obs_load, 1'b1);
        finish_prog();

        // Authorised page load with upper address bits set.
        enable_seq(2'b11);
        chk("R4 upper bits ignored", obs_seq, 1'b1);
        wr(17'h10400, 8'h44);
        chk("R6 authorised store", obs_store, 1'b1);
        finish_prog();
        chk("R5 protect stays 1", obs_prot, 1'b1);

        // Enable with no data.
        enable_seq(2'b00);
        finish_prog();
        chk("R5 enable without data", obs_prot, 1'b1);

        // Mismatch returns to idle; the next AA write is ordinary.
        wr(A5, 8'hAA);
        wr(A5, 8'hAA);
        chk("R10 mismatch not flagged", obs_seq, 1'b0);
        chk("R10 mismatch ordinary no store", obs_store, 1'b0);
        wr(A2, 8'h55);
        chk("R10 matcher idle after mismatch", obs_seq, 1'b0);
        finish_prog();

        // Gap boundary: exactly T continues, T+1 abandons.
        wr(A5, 8'hAA);
        idle(T - 1);
        wr(A2, 8'h55);
        chk("R11 gap of T continues", obs_seq, 1'b1);
        idle(T);
        wr(A5, 8'hA0);
        chk("R11 gap of T+1 abandons", obs_seq, 1'b0);
        finish_prog();

        // Window closes after timeout.
        enable_seq(2'b00);
        idle(T);
        wr(17'h00500, 8'h55);
        chk("R11 window closed store", obs_store, 1'b0);
        finish_prog();

        // Soft reset mid-sequence keeps protection, drops matcher.
        wr(A5, 8'hAA);
        soft_reset();
        cyc1(0, '0, '0, 0);
        chk("R12 protect kept over soft reset", obs_prot, 1'b1);
        wr(A2, 8'h55);
        chk("R12 matcher idle after soft reset", obs_seq, 1'b0);
        finish_prog();

        // Disable sequence, then data, then done.
        wr(A5, 8'hAA); wr(A2, 8'h55); wr(A5, 8'h80);
        chk("R3 disable third byte flagged", obs_seq, 1'b1);
        wr(A5, 8'hAA); wr(A2, 8'h55); wr(A5, 8'h20);
        chk("R3 disable last byte not stored", obs_store, 1'b0);
        chk("R9 disable last byte load", obs_load, 1'b1);
        wr(17'h00600, 8'h66);
        chk("R6 store after disable sequence", obs_store, 1'b1);
        finish_prog();
        chk("R5 protect cleared", obs_prot, 1'b0);
        wr(17'h00700, 8'h77);
        chk("R8 store after unprotect", obs_store, 1'b1);

        // Hard reset clears protection.
        enable_seq(2'b00);
        finish_prog();
        hard_reset();
        idle(1);
        chk("R1 hard reset clears protect", obs_prot, 1'b0);
        wr(A2, 8'h55);
        chk("R1 matcher idle after hard reset", obs_seq, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule